// File: doc/BRIEF.md
# Synthesizer Serial Command Sequencer

This block sits between a controller and the 16-bit serial control port of a direct digital synthesizer. The controller hands it one high-level command at a time. Each command is turned into a fixed series of 16-bit words on a write-only SPI link: set up the part, load either frequency register with a 28-bit tuning word, load either phase register with a 12-bit offset, pick the active frequency or phase register, or change the waveform and sign-output settings.

The sequencer holds a shadow of the synthesizer's control word. Commands that change one or more control bits edit the shadow and then resend the whole word. A 28-bit tuning word needs three words on the wire. The first word arms two-write loading. The second carries the low 14 bits and the third carries the high 14 bits, and both data words are tagged with the register's address prefix.

The serial clock is the system clock divided by a parameter. The requester sees a simple ready/valid handshake, and ready stays low until the last word of a command has left the block.

Top module: `dds_cmd_seq`

## Requirements
- R1: After reset, ready, spi_cs_n and spi_sclk are 1, spi_mosi is 0, and the shadow control word is 0x0000.
- R2: Each word is 16 bits, sent MSB first in SPI mode 2. spi_sclk idles high and toggles only while spi_cs_n is low. spi_mosi is stable while spi_sclk is low and is sampled on falling edges. spi_cs_n falls while spi_sclk is high and rises only after the final rising edge.
- R3: Between two words of one command, spi_cs_n stays high for at least 2*CLK_HALF system clock cycles.
- R4: cmd_op=1 (frequency load) sends three words. The first is 0x2000. The second is P|data[13:0] and the third is P|data[27:14], where P=0x4000 when cmd_sel=0 and P=0x8000 when cmd_sel=1.
- R5: cmd_op=2 (phase load) sends one word: 0xC000|data[11:0] when cmd_sel=0, or 0xE000|data[11:0] when cmd_sel=1. Higher data bits are ignored.
- R6: cmd_op=3 writes cmd_sel into shadow bit 0x0800, and cmd_op=4 writes it into shadow bit 0x0400. Each then sends the whole shadow word.
- R7: cmd_op=5 clears shadow mask 0x003A and ORs in a code chosen by data[1:0]: 0 gives 0x0000, 1 gives 0x0028, 2 gives 0x0020, 3 gives 0x0038. It then sends the shadow word. Other data bits are ignored.
- R8: cmd_op=6 with cmd_sel=1 (triangle) clears mask 0x003A and sets 0x0002. With cmd_sel=0 (sine) it clears only 0x0002. Either way it then sends the shadow word.
- R9: cmd_op=0 (initialize) sends eleven words in this order, with S the shadow word: S|0x0100 twice, then 0x2000, 0x4000, 0x4000, then 0x2000, 0x8000, 0x8000, then 0xC000, 0xE000, and finally S with 0x0100 clear.
- R10: A command is taken only when cmd_valid and ready are both 1. Ready goes low on the next cycle and stays low through the final word and its trailing gap. A cmd_valid while ready is low has no effect.
- R11: cmd_op=7 is reserved. It is not accepted, ready stays high, and no word is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 3 | Command code (see R4 to R11) |
| cmd_sel | input | 1 | Register select or mode choice bit |
| cmd_data | input | 28 | Tuning word, phase value or sign-output code |
| ready | output | 1 | High when a new command can be taken |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the synthesizer |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The assertions check the framing on every cycle: the clock stays high whenever chip select is high, data holds still while the clock is low, and chip select edges fall inside clock-high phases. They also watch the handshake, namely that ready stays low while a frame is open and that a reserved code leaves ready high. The content of each word can only be shown by the bench's scenarios, which rebuild the words at the pins. This covers the three-word tuning split, the phase prefixes, the order of the initialization words and the way the shadow word builds up over a run of commands. The bench scenarios also cover the bit count per frame and the smallest gap between frames.

// File: rtl/dds_cmd_seq.sv
module dds_cmd_seq #(
  parameter int CLK_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic        cmd_sel,
  input  logic [27:0] cmd_data,
  output logic        ready,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_cs_n
);

  localparam int CW = $clog2(2*CLK_HALF + 1);
  localparam logic [CW-1:0] HLIM = CW'(CLK_HALF - 1);
  localparam logic [CW-1:0] GLIM = CW'(2*CLK_HALF - 1);

  localparam logic [2:0] OP_INIT  = 3'd0;
  localparam logic [2:0] OP_FREQ  = 3'd1;
  localparam logic [2:0] OP_PHASE = 3'd2;
  localparam logic [2:0] OP_FSEL  = 3'd3;
  localparam logic [2:0] OP_PSEL  = 3'd4;
  localparam logic [2:0] OP_SIGN  = 3'd5;
  localparam logic [2:0] OP_WAVE  = 3'd6;
  localparam logic [2:0] OP_RSVD  = 3'd7;

  localparam logic [15:0] B_RST  = 16'h0100;
  localparam logic [15:0] B_FSEL = 16'h0800;
  localparam logic [15:0] B_PSEL = 16'h0400;
  localparam logic [15:0] B_TRI  = 16'h0002;
  localparam logic [15:0] M_SIGN = 16'h003A;
  localparam logic [15:0] W_ARM  = 16'h2000;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_LEAD, S_LO, S_HI, S_TAIL, S_GAP} st_t;

  st_t st;
  logic [CW-1:0] dcnt;
  logic [4:0]  nbit;
  logic [3:0]  widx, nwords;
  logic [15:0] shreg, shadow, sh_nx, word, sign_code;
  logic [15:0] fpfx, ppfx;
  logic [2:0]  op_q;
  logic        sel_q;
  logic [27:0] dat_q;
  logic        accept, tick;

  assign ready    = (st == S_IDLE);
  assign accept   = ready & cmd_valid & (cmd_op != OP_RSVD);
  assign tick     = (dcnt == ((st == S_GAP) ? GLIM : HLIM));
  assign spi_cs_n = !(st == S_LEAD || st == S_LO || st == S_HI || st == S_TAIL);
  assign spi_sclk = (st != S_LO);
  assign spi_mosi = !spi_cs_n & shreg[15];
  assign fpfx     = sel_q ? 16'h8000 : 16'h4000;
  assign ppfx     = sel_q ? 16'hE000 : 16'hC000;

  always_comb begin
    case (cmd_data[1:0])
      2'd1:    sign_code = 16'h0028;
      2'd2:    sign_code = 16'h0020;
      2'd3:    sign_code = 16'h0038;
      default: sign_code = 16'h0000;
    endcase
  end

  always_comb begin
    sh_nx = shadow;
    case (cmd_op)
      OP_INIT: sh_nx = shadow & ~B_RST;
      OP_FSEL: sh_nx = cmd_sel ? (shadow | B_FSEL) : (shadow & ~B_FSEL);
      OP_PSEL: sh_nx = cmd_sel ? (shadow | B_PSEL) : (shadow & ~B_PSEL);
      OP_SIGN: sh_nx = (shadow & ~M_SIGN) | sign_code;
      OP_WAVE: sh_nx = cmd_sel ? ((shadow & ~M_SIGN) | B_TRI) : (shadow & ~B_TRI);
      default: sh_nx = shadow;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_INIT:  nwords = 4'd11;
      OP_FREQ:  nwords = 4'd3;
      default:  nwords = 4'd1;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_FREQ: begin
        case (widx)
          4'd0:    word = W_ARM;
          4'd1:    word = fpfx | {2'b00, dat_q[13:0]};
          default: word = fpfx | {2'b00, dat_q[27:14]};
        endcase
      end
      OP_PHASE: word = ppfx | {4'h0, dat_q[11:0]};
      OP_INIT: begin
        case (widx)
          4'd0, 4'd1: word = shadow | B_RST;
          4'd2, 4'd5: word = W_ARM;
          4'd3, 4'd4: word = 16'h4000;
          4'd6, 4'd7: word = 16'h8000;
          4'd8:       word = 16'hC000;
          4'd9:       word = 16'hE000;
          default:    word = shadow;
        endcase
      end
      default: word = shadow;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dcnt   <= '0;
      nbit   <= '0;
      widx   <= '0;
      shreg  <= '0;
      shadow <= '0;
      op_q   <= '0;
      sel_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      dcnt <= (st == S_IDLE || st == S_LOAD || tick) ? '0 : dcnt + 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          op_q   <= cmd_op;
          sel_q  <= cmd_sel;
          dat_q  <= cmd_data;
          shadow <= sh_nx;
          widx   <= '0;
          st     <= S_LOAD;
        end
        S_LOAD: begin
          if (widx == nwords) st <= S_IDLE;
          else begin
            shreg <= word;
            nbit  <= '0;
            st    <= S_LEAD;
          end
        end
        S_LEAD: if (tick) st <= S_LO;
        S_LO: if (tick) begin
          shreg <= {shreg[14:0], 1'b0};
          nbit  <= nbit + 5'd1;
          st    <= S_HI;
        end
        S_HI: if (tick) st <= (nbit == 5'd16) ? S_TAIL : S_LO;
        S_TAIL: if (tick) begin
          widx <= widx + 4'd1;
          st   <= S_GAP;
        end
        S_GAP: if (tick) st <= S_LOAD;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dds_cmd_seq_chk.sv
module dds_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       ready,
  input logic       spi_sclk,
  input logic       spi_mosi,
  input logic       spi_cs_n
);

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);

  // R2
  cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> spi_sclk);

  // R2
  cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $past(spi_sclk));

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && !spi_sclk && !$fell(spi_sclk)) |-> $stable(spi_mosi));

  // R10
  busy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !ready);

  // R10
  take_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_valid && cmd_op != 3'd7) |=> !ready);

  // R11
  rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_valid && cmd_op == 3'd7) |=> ready);

endmodule

bind dds_cmd_seq dds_cmd_seq_chk u_dds_cmd_seq_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .ready(ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/dds_cmd_seq_bench.sv
`timescale 1ns/1ps
module dds_cmd_seq_bench;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_sel = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [27:0] cmd_data = '0;
  logic ready, spi_sclk, spi_mosi, spi_cs_n;

  int tests = 0, fails = 0;

  dds_cmd_seq #(.CLK_HALF(HALF)) u_dds_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_data(cmd_data), .ready(ready),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  always #2 clk = ~clk;

  // op[81:79] sel[78] data[77:50] n[49:48] w0[47:32] w1[31:16] w2[15:0]
  localparam logic [81:0] VEC [0:13] = '{
    {3'd1, 1'b0, 28'h051EB85, 2'd3, 16'h2000, 16'h6B85, 16'h4147},
    {3'd1, 1'b1, 28'hFFFFFFF, 2'd3, 16'h2000, 16'hBFFF, 16'hBFFF},
    {3'd2, 1'b0, 28'h1234ABC, 2'd1, 16'hCABC, 16'h0000, 16'h0000},
    {3'd2, 1'b1, 28'h0000FFF, 2'd1, 16'hEFFF, 16'h0000, 16'h0000},
    {3'd3, 1'b1, 28'h0000000, 2'd1, 16'h0800, 16'h0000, 16'h0000},
    {3'd4, 1'b1, 28'h0000000, 2'd1, 16'h0C00, 16'h0000, 16'h0000},
    {3'd5, 1'b0, 28'h0000001, 2'd1, 16'h0C28, 16'h0000, 16'h0000},
    {3'd6, 1'b1, 28'h0000000, 2'd1, 16'h0C02, 16'h0000, 16'h0000},
    {3'd5, 1'b0, 28'hFFFFFF3, 2'd1, 16'h0C38, 16'h0000, 16'h0000},
    {3'd6, 1'b0, 28'h0000000, 2'd1, 16'h0C38, 16'h0000, 16'h0000},
    {3'd5, 1'b0, 28'h0000002, 2'd1, 16'h0C20, 16'h0000, 16'h0000},
    {3'd3, 1'b0, 28'h0000000, 2'd1, 16'h0420, 16'h0000, 16'h0000},
    {3'd5, 1'b0, 28'h0000000, 2'd1, 16'h0400, 16'h0000, 16'h0000},
    {3'd4, 1'b0, 28'h0000000, 2'd1, 16'h0000, 16'h0000, 16'h0000}
  };

  localparam logic [15:0] INIT_MID [0:10] = '{
    16'h0000, 16'h0000, 16'h2000, 16'h4000, 16'h4000, 16'h2000,
    16'h8000, 16'h8000, 16'hC000, 16'hE000, 16'h0000
  };

  logic [15:0] cap [0:255];
  int cap_n = 0, nb = 0, bad_frames = 0, gap = 0, min_gap = 1000;
  logic [15:0] sh = '0;
  logic prev_sclk = 1'b1, prev_cs = 1'b1, seen = 1'b0;

  always @(negedge clk) begin
    if (!spi_cs_n && prev_sclk && !spi_sclk) begin
      sh = {sh[14:0], spi_mosi};
      nb++;
    end
    if (spi_cs_n && !prev_cs) begin
      cap[cap_n[7:0]] = sh;
      cap_n++;
      if (nb != 16) bad_frames++;
      nb = 0;
      gap = 1;
      seen = 1'b1;
    end else if (spi_cs_n) gap++;
    if (!spi_cs_n && prev_cs && seen && gap < min_gap) min_gap = gap;
    prev_sclk = spi_sclk;
    prev_cs = spi_cs_n;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R9";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic run_cmd(input logic [2:0] op, input logic sel, input logic [27:0] d, output int base);
    while (!ready) @(negedge clk);
    base = cap_n;
    cmd_op = op; cmd_sel = sel; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op != 3'd7) check("R10 ready low after accept", {31'd0, ready}, 32'd0);
    while (!ready) @(negedge clk);
  endtask

  task automatic run_init(input logic [15:0] s);
    int base;
    run_cmd(3'd0, 1'b0, 28'd0, base);
    check("R9 word count", cap_n - base, 32'd11);
    for (int k = 0; k < 11; k++) begin
      logic [15:0] e;
      e = (k < 2) ? (s | 16'h0100) : (k == 10) ? s : INIT_MID[k];
      check("R9 init word", {16'd0, cap[(base + k) % 256]}, {16'd0, e});
    end
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", {31'd0, ready}, 32'd1);
    check("R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
    check("R1 sclk", {31'd0, spi_sclk}, 32'd1);
    check("R1 mosi", {31'd0, spi_mosi}, 32'd0);

    // R1 / R9: shadow is zero after reset, so init ends with 0x0000
    run_init(16'h0000);

    for (int i = 0; i < 14; i++) begin
      logic [81:0] v;
      int n;
      v = VEC[i];
      n = int'(v[49:48]);
      run_cmd(v[81:79], v[78], v[77:50], base);
      check(req_of(v[81:79]), cap_n - base, n);
      check(req_of(v[81:79]), {16'd0, cap[base % 256]}, {16'd0, v[47:32]});
      if (n == 3) begin
        check(req_of(v[81:79]), {16'd0, cap[(base + 1) % 256]}, {16'd0, v[31:16]});
        check(req_of(v[81:79]), {16'd0, cap[(base + 2) % 256]}, {16'd0, v[15:0]});
      end
    end

    // R9 with a non-zero shadow word
    run_cmd(3'd3, 1'b1, 28'd0, base);
    check("R6 select freq 1", {16'd0, cap[base % 256]}, 32'h0800);
    run_init(16'h0800);

    // R10: request while busy is dropped
    while (!ready) @(negedge clk);
    base = cap_n;
    cmd_op = 3'd2; cmd_sel = 1'b0; cmd_data = 28'h0000123; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_op = 3'd2; cmd_sel = 1'b1; cmd_data = 28'h0000FFF;
    repeat (10) @(negedge clk);
    cmd_valid = 1'b0;
    while (!ready) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R10 busy request dropped count", cap_n - base, 32'd1);
    check("R10 accepted word", {16'd0, cap[base % 256]}, 32'h0000C123);

    // R11: reserved op
    base = cap_n;
    cmd_op = 3'd7; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R11 ready stays high", {31'd0, ready}, 32'd1);
    repeat (30) begin
      @(negedge clk);
      if (!spi_cs_n || !ready) check("R11 no activity", {30'd0, ready, spi_cs_n}, 32'd3);
    end
    check("R11 no words", cap_n - base, 32'd0);

    check("R2 all frames 16 bits", bad_frames, 32'd0);
    check("R3 inter-word gap", {31'd0, min_gap >= 2*HALF}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule